// File: doc/BRIEF.md
# Dual-Quad SPI Host Transaction Engine

This block is the host side of a flash bus made of two 4-bit SPI lanes. The two lanes share one serial clock and one chip select and together offer eight data lines. A single request starts one transaction. The request carries an 8-bit instruction, an address (24 or 32 bits), a dummy clock count from 0 to 15, a byte count and a direction. Write bytes are taken from a valid/ready port as the engine needs them. Read bytes are handed out on a second valid/ready port.

Each part of the transaction uses the lines in its own way. The instruction goes out one bit per clock on lines 0 and 4 only. Each address nibble is driven on lines 0–3 and copied onto lines 4–7. Data moves one whole byte per transfer across all eight lines, with the upper nibble on lines 4–7. The serial clock idles low. Outputs change only after a falling edge, so they are stable when the device captures them on the rising edge. Reads run either single-rate (one byte per rising edge) or double-rate (one byte per edge).

The sequencer has these states:
- IDLE: ready for a request.
- CMD: instruction bits.
- ADDR: address nibbles.
- DUMMY: all output enables released.
- WDATA: write bytes.
- RDATA: read bytes.
- END: the clock is parked low while the chip select is still low.
- GAP: the chip select is high.

Transitions:
- IDLE→CMD when a request arrives.
- CMD→ADDR after the eighth bit.
- ADDR→DUMMY when the dummy count is not zero.
- ADDR or DUMMY→WDATA, RDATA or END, depending on direction and byte count.
- WDATA or RDATA→END after the last byte.
- END→GAP after one cycle.
- GAP→IDLE after `GAP_CYC` cycles.

Every move between CMD and RDATA happens on a falling-edge tick of the serial clock.

Top module: `dqspi_engine`

## Requirements
- R1: After reset, and whenever `spi_cs_n` is high, `spi_sck` is low and `io_oe` is 0. After reset, `req_ready` is 1 and `rd_valid` and `wr_ready` are 0.
- R2: The instruction is sent MSB first, one bit per SCK cycle, on `io_o[0]` and `io_o[4]` with identical values. `io_oe` is 8'h11 during these eight cycles.
- R3: The address is sent most significant nibble first: 8 nibbles when `req_addr32`=1, else the low 24 bits as 6 nibbles. Each nibble sits on `io_o[3:0]` (bit 3 on line 3) and is repeated on `io_o[7:4]`, with `io_oe`=8'hFF.
- R4: Exactly `req_dummy` SCK cycles follow the address, with `io_oe`=0.
- R5: A write moves one byte per SCK cycle whatever `req_ddr` is. The byte is driven with bits 7:4 on lines 7–4 and `io_oe`=8'hFF. Bytes are taken in order from the write port, and the clock pauses while `wr_valid` is low.
- R6: A single-rate read (`req_ddr`=0) samples one byte from `io_i` on each SCK rising edge and needs `req_len` rising edges.
- R7: A double-rate read (`req_ddr`=1) samples one byte on each SCK edge, starting at a rising edge, and needs ceil(`req_len`/2) rising edges.
- R8: With `req_len`=0 there is no data phase: no write byte is taken and no read byte is delivered.
- R9: Each SCK half period lasts max(1,`cfg_div`) system clocks unless the engine is stalled by a handshake. So SCK runs at the system clock divided by at least 2.
- R10: Between transactions `spi_cs_n` stays high for at least `GAP_CYC`+1 system clocks (3 by default). The checker's lower bound is 2.
- R11: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold and no further byte is sampled.
- R12: While SCK is high, `io_o` does not change: values are launched only at falling edges or at the start of the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transaction request strobe |
| req_ready | output | 1 | Engine idle, request accepted |
| req_cmd | input | 8 | Instruction byte |
| req_addr | input | 32 | Address |
| req_addr32 | input | 1 | 1: 32-bit address, 0: 24-bit |
| req_dummy | input | 4 | Dummy SCK cycles |
| req_len | input | LEN_W | Data byte count |
| req_write | input | 1 | 1: write, 0: read |
| req_ddr | input | 1 | Double-rate read data |
| cfg_div | input | DIV_W | SCK half period in system clocks (0 acts as 1) |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken this cycle |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Shared chip select, active low |
| io_o | output | 8 | IO line output values |
| io_oe | output | 8 | IO line output enables |
| io_i | input | 8 | IO line input values |

## Verification
A request is taken at the clock edge where `req_valid` meets `req_ready`. The chip select falls at that edge, and the first rising edge of SCK comes max(1,`cfg_div`) clocks later. The bench's flash model therefore watches the ports on the falling edge of the system clock and reacts to every SCK change one half-cycle after the edge that produced it. It captures instruction, address and write data at rising edges. It drives read bytes right after the edges where the engine will next sample. Handshake transfers are counted on the falling clock half before the edge that completes them, so data and counts line up with the engine's sampling edges under both steady and stalled handshakes.

// File: rtl/dqspi_pkg.sv
package dqspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_WDATA,
        ST_RDATA,
        ST_END,
        ST_GAP
    } dq_state_e;

    typedef enum logic [1:0] {
        DRV_NONE,
        DRV_CMD,
        DRV_ADDR,
        DRV_DATA
    } drv_e;

endpackage

// File: rtl/dqspi_sck_gen.sv
module dqspi_sck_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    input  logic [DIV_W-1:0] half_div,
    output logic             sck,
    output logic             term,
    output logic             tick_rise,
    output logic             tick_fall
);
    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] limit;
    logic             tick;

    always_comb begin
        limit     = (half_div == '0) ? DIV_W'(1) : half_div;
        term      = run && (hcnt == limit - DIV_W'(1));
        tick      = term && !hold;
        tick_rise = tick && !sck;
        tick_fall = tick && sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            sck  <= 1'b0;
        end else if (!run) begin
            hcnt <= '0;
            sck  <= 1'b0;
        end else if (term) begin
            if (!hold) begin
                hcnt <= '0;
                sck  <= !sck;
            end
        end else begin
            hcnt <= hcnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/dqspi_lane_mux.sv
module dqspi_lane_mux
    import dqspi_pkg::*;
#(
    parameter int LANES = 2
) (
    input  drv_e                 drv,
    input  logic                 cmd_bit,
    input  logic [3:0]           nib,
    input  logic [LANES*4-1:0]   wbyte,
    output logic [LANES*4-1:0]   io_o,
    output logic [LANES*4-1:0]   io_oe
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (drv)
                DRV_CMD: begin
                    io_o[g*4 +: 4]  = {3'b000, cmd_bit};
                    io_oe[g*4 +: 4] = 4'b0001;
                end
                DRV_ADDR: begin
                    io_o[g*4 +: 4]  = nib;
                    io_oe[g*4 +: 4] = 4'b1111;
                end
                DRV_DATA: begin
                    io_o[g*4 +: 4]  = wbyte[g*4 +: 4];
                    io_oe[g*4 +: 4] = 4'b1111;
                end
                default: begin
                    io_o[g*4 +: 4]  = 4'b0000;
                    io_oe[g*4 +: 4] = 4'b0000;
                end
            endcase
        end
    end
endmodule

// File: rtl/dqspi_engine.sv
module dqspi_engine
    import dqspi_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int DIV_W   = 4,
    parameter int GAP_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [7:0]       req_cmd,
    input  logic [31:0]      req_addr,
    input  logic             req_addr32,
    input  logic [3:0]       req_dummy,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_write,
    input  logic             req_ddr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [7:0]       wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             spi_sck,
    output logic             spi_cs_n,
    output logic [7:0]       io_o,
    output logic [7:0]       io_oe,
    input  logic [7:0]       io_i
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    dq_state_e        state, state_nx, fall_nx, data_st;
    drv_e             drv;
    logic [7:0]       sh_cmd;
    logic [31:0]      sh_addr;
    logic [3:0]       ucnt, nib_last, dummy_r;
    logic [LEN_W-1:0] bcnt, len_r;
    logic             wr_r, ddr_r;
    logic [DIV_W-1:0] div_r;
    logic [7:0]       wbyte;
    logic [GAP_W-1:0] gap_cnt;
    logic             run, hold, term, tick_rise, tick_fall;
    logic             rd_take, wr_launch, rd_sample;

    dqspi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .hold      (hold),
        .half_div  (div_r),
        .sck       (spi_sck),
        .term      (term),
        .tick_rise (tick_rise),
        .tick_fall (tick_fall)
    );

    dqspi_lane_mux #(.LANES(2)) u_mux (
        .drv     (drv),
        .cmd_bit (sh_cmd[7]),
        .nib     (sh_addr[31:28]),
        .wbyte   (wbyte),
        .io_o    (io_o),
        .io_oe   (io_oe)
    );

    // Handshake-driven pacing of the serial clock
    always_comb begin
        rd_take   = (state == ST_RDATA) && (bcnt != len_r) && (ddr_r || !spi_sck);
        wr_launch = spi_sck && wr_r && (fall_nx == ST_WDATA);
        hold      = (wr_launch && !wr_valid) || (rd_take && rd_valid);
        wr_ready  = wr_launch && term;
        rd_sample = rd_take && (tick_rise || tick_fall);
    end

    // Target state at the next falling SCK tick
    always_comb begin
        data_st = (len_r == '0) ? ST_END : (wr_r ? ST_WDATA : ST_RDATA);
        fall_nx = state;
        unique case (state)
            ST_CMD:   if (ucnt == 4'd7) fall_nx = ST_ADDR;
            ST_ADDR:  if (ucnt == nib_last)
                          fall_nx = (dummy_r != 4'd0) ? ST_DUMMY : data_st;
            ST_DUMMY: if (ucnt == dummy_r - 4'd1) fall_nx = data_st;
            ST_WDATA: if (bcnt == len_r) fall_nx = ST_END;
            ST_RDATA: if (bcnt + LEN_W'(rd_take) == len_r) fall_nx = ST_END;
            default:  fall_nx = state;
        endcase
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_CMD;
            ST_END:  state_nx = ST_GAP;
            ST_GAP:  if (gap_cnt == GAP_W'(GAP_CYC - 1)) state_nx = ST_IDLE;
            default: if (tick_fall) state_nx = fall_nx;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath: shifters, counters, captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_cmd   <= '0;
            sh_addr  <= '0;
            ucnt     <= '0;
            nib_last <= '0;
            dummy_r  <= '0;
            bcnt     <= '0;
            len_r    <= '0;
            wr_r     <= 1'b0;
            ddr_r    <= 1'b0;
            div_r    <= DIV_W'(1);
            wbyte    <= '0;
            gap_cnt  <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                sh_cmd   <= req_cmd;
                sh_addr  <= req_addr32 ? req_addr : {req_addr[23:0], 8'h00};
                nib_last <= req_addr32 ? 4'd7 : 4'd5;
                dummy_r  <= req_dummy;
                len_r    <= req_len;
                wr_r     <= req_write;
                ddr_r    <= req_ddr;
                div_r    <= cfg_div;
                ucnt     <= '0;
                bcnt     <= '0;
                gap_cnt  <= '0;
            end
            if (tick_fall) begin
                unique case (state)
                    ST_CMD: begin
                        if (ucnt == 4'd7) ucnt <= '0;
                        else begin
                            sh_cmd <= {sh_cmd[6:0], 1'b0};
                            ucnt   <= ucnt + 4'd1;
                        end
                    end
                    ST_ADDR: begin
                        if (ucnt == nib_last) ucnt <= '0;
                        else begin
                            sh_addr <= {sh_addr[27:0], 4'h0};
                            ucnt    <= ucnt + 4'd1;
                        end
                    end
                    ST_DUMMY: ucnt <= ucnt + 4'd1;
                    default: ;
                endcase
                if (wr_launch) begin
                    wbyte <= wr_data;
                    bcnt  <= bcnt + LEN_W'(1);
                end
            end
            if (rd_sample) begin
                rd_data  <= io_i;
                rd_valid <= 1'b1;
                bcnt     <= bcnt + LEN_W'(1);
            end else if (rd_ready) begin
                rd_valid <= 1'b0;
            end
            if (state == ST_GAP) gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = (state == ST_IDLE);
        spi_cs_n  = (state == ST_IDLE) || (state == ST_GAP);
        run       = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DUMMY)
                 || (state == ST_WDATA) || (state == ST_RDATA);
        unique case (state)
            ST_CMD:   drv = DRV_CMD;
            ST_ADDR:  drv = DRV_ADDR;
            ST_WDATA: drv = DRV_DATA;
            default:  drv = DRV_NONE;
        endcase
    end
endmodule

// File: rtl/dqspi_engine_chk.sv
module dqspi_engine_chk
    import dqspi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_sck,
    input logic       spi_cs_n,
    input logic [7:0] io_o,
    input logic [7:0] io_oe,
    input dq_state_e  state,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       wr_ready
);
    logic [2:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_cnt <= 3'd7;
        else if (spi_cs_n) hi_cnt <= (hi_cnt == 3'd7) ? hi_cnt : hi_cnt + 3'd1;
        else               hi_cnt <= 3'd0;
    end

    // R1
    idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_sck && io_oe == 8'h00));

    // R2
    cmd_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> (io_oe == 8'h11 && io_o[0] == io_o[4]));

    // R3
    addr_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> (io_o[3:0] == io_o[7:4] && io_oe == 8'hFF));

    // R4
    dummy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |-> (io_oe == 8'h00));

    // R5
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> (!spi_cs_n && spi_sck));

    // R10
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_cnt >= 3'd2));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    // R12
    launch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(io_o));
endmodule

bind dqspi_engine dqspi_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sck  (spi_sck),
    .spi_cs_n (spi_cs_n),
    .io_o     (io_o),
    .io_oe    (io_oe),
    .state    (state),
    .rd_valid (rd_valid),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .wr_ready (wr_ready)
);

// File: tb/test_dqspi_engine.sv
`timescale 1ns/1ps
module test_dqspi_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic        req_addr32 = 1'b0;
    logic [3:0]  req_dummy = '0;
    logic [7:0]  req_len = '0;
    logic        req_write = 1'b0;
    logic        req_ddr = 1'b0;
    logic [3:0]  cfg_div = 4'd1;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [7:0]  wr_data = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b0;
    logic [7:0]  rd_data;
    logic        spi_sck, spi_cs_n;
    logic [7:0]  io_o, io_oe;
    logic [7:0]  io_i = '0;

    always #10 clk = !clk;

    dqspi_engine i_dqspi_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_addr(req_addr), .req_addr32(req_addr32),
        .req_dummy(req_dummy), .req_len(req_len), .req_write(req_write),
        .req_ddr(req_ddr), .cfg_div(cfg_div), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_ready(rd_ready), .rd_data(rd_data), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .io_o(io_o), .io_oe(io_oe), .io_i(io_i)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // transaction context and flash model state
    logic [7:0]  t_cmd;
    logic [31:0] t_addr;
    int t_nib, t_dum, t_len;
    bit t_wr, t_ddr, t_stall, t_act;
    int rc, didx, wcnt, wbad, widx, ridx, rbad, viol, idle_bad;
    int hp_cnt, min_hp, hi_run, last_gap, cyc;
    bit dstart, prev_sck, prev_cs;
    logic [7:0]  cap_cmd;
    logic [31:0] cap_addr;

    function automatic logic [7:0] rpat(int k);
        return t_addr[7:0] ^ 8'(k * 29 + 60);
    endfunction

    function automatic logic [7:0] wpat(int k);
        return t_cmd + 8'(k * 53);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        // user-side handshakes
        wr_valid = t_act && t_wr && (!t_stall || (cyc % 3 != 0));
        wr_data  = wpat(widx);
        if (wr_valid && wr_ready) widx++;
        rd_ready = !t_stall || (cyc % 4 != 1);
        if (rd_valid && rd_ready) begin
            if (rd_data != rpat(ridx)) rbad++;
            ridx++;
        end
        // flash model
        if (!spi_cs_n) begin
            if (spi_sck != prev_sck) begin
                if (hp_cnt < min_hp) min_hp = hp_cnt;
                hp_cnt = 1;
            end else hp_cnt++;
            if (spi_sck && !prev_sck) begin
                rc++;
                if (rc <= 8) begin
                    cap_cmd = {cap_cmd[6:0], io_o[0]};
                    if (io_oe != 8'h11 || io_o[4] != io_o[0]) viol++;
                end else if (rc <= 8 + t_nib) begin
                    cap_addr = {cap_addr[27:0], io_o[3:0]};
                    if (io_oe != 8'hFF || io_o[7:4] != io_o[3:0]) viol++;
                end else if (rc <= 8 + t_nib + t_dum) begin
                    if (io_oe != 8'h00) viol++;
                end else if (t_wr) begin
                    if (io_oe != 8'hFF) viol++;
                    if (io_o != wpat(wcnt)) wbad++;
                    wcnt++;
                end else begin
                    if (io_oe != 8'h00) viol++;
                end
                if (t_ddr && !t_wr && dstart) begin
                    io_i = rpat(didx);
                    didx++;
                end
            end
            if (!spi_sck && prev_sck) begin
                if (!t_wr && !dstart && rc == 8 + t_nib + t_dum) begin
                    dstart = 1;
                    io_i = rpat(0);
                    didx = 1;
                end else if (!t_wr && dstart) begin
                    io_i = rpat(didx);
                    didx++;
                end
            end
            if (prev_cs) last_gap = hi_run;
            hi_run = 0;
        end else begin
            if (spi_sck || io_oe != 8'h00) idle_bad++;
            hi_run++;
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    task automatic run_txn(int n, bit a32, int dum, int len, bit wr, bit ddr, int div);
        int eff, exp_rise, tmo;
        @(posedge clk);
        t_cmd = 8'h0B + 8'(n * 7);
        t_addr = 32'h1234_5678 + 32'(n) * 32'h0F1E_2D3B;
        t_nib = a32 ? 8 : 6; t_dum = dum; t_len = len;
        t_wr = wr; t_ddr = ddr; t_stall = n[0]; t_act = 1;
        rc = 0; didx = 0; wcnt = 0; wbad = 0; widx = 0; ridx = 0; rbad = 0;
        viol = 0; hp_cnt = 0; min_hp = 1000; dstart = 0; cap_cmd = '0; cap_addr = '0;
        @(negedge clk);
        req_valid = 1; req_cmd = t_cmd; req_addr = t_addr; req_addr32 = a32;
        req_dummy = 4'(dum); req_len = 8'(len); req_write = wr; req_ddr = ddr;
        cfg_div = 4'(div);
        @(negedge clk);
        req_valid = 0;
        tmo = 0;
        while (!req_ready && tmo < 20000) begin @(negedge clk); tmo++; end
        t_act = 0;
        eff = (div == 0) ? 1 : div;
        exp_rise = 8 + t_nib + dum + ((len == 0) ? 0 : (wr ? len : (ddr ? (len + 1) / 2 : len)));
        chk(tmo < 20000, "R1 return to idle", tmo, 0);
        chk(cap_cmd == t_cmd, "R2 instruction bits", cap_cmd, t_cmd);
        chk(cap_addr == (a32 ? t_addr : {8'h00, t_addr[23:0]}), "R3 address nibbles",
            cap_addr, a32 ? t_addr : {8'h00, t_addr[23:0]});
        chk(viol == 0, "R2/R3/R4 line usage per phase", viol, 0);
        chk(rc == exp_rise, wr ? "R5 rising edges" : (ddr ? "R7 rising edges" : "R6 rising edges"),
            rc, exp_rise);
        chk(min_hp == eff, "R9 half period", min_hp, eff);
        if (wr) begin
            chk(wcnt == len && widx == len, "R5 R8 write byte count", wcnt, len);
            chk(wbad == 0, "R5 write byte values", wbad, 0);
        end else begin
            chk(ridx == len, ddr ? "R7 R8 read count" : "R6 R8 read count", ridx, len);
            chk(rbad == 0, "R11 read byte values", rbad, 0);
        end
        if (n > 0) chk(last_gap >= 3, "R10 chip select gap", last_gap, 3);
        chk(idle_bad == 0, "R1 idle lines", idle_bad, 0);
    endtask

    initial begin
        int dums[4] = '{0, 1, 3, 15};
        int lens[4] = '{0, 1, 2, 5};
        int divs[2] = '{0, 3};
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(spi_cs_n && !spi_sck && io_oe == 8'h00, "R1 reset lines", {spi_cs_n, spi_sck}, 2);
        chk(req_ready && !rd_valid && !wr_ready, "R1 reset handshakes",
            {req_ready, rd_valid, wr_ready}, 4);
        n = 0;
        for (int a = 0; a < 2; a++)
            for (int d = 0; d < 4; d++)
                for (int l = 0; l < 4; l++)
                    for (int w = 0; w < 2; w++)
                        for (int r = 0; r < 2; r++)
                            for (int v = 0; v < 2; v++) begin
                                run_txn(n, a[0], dums[d], lens[l], w[0], r[0], divs[v]);
                                n++;
                            end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule